// File: doc/BRIEF.md
# Indirect Table Access Port

This block gives software a narrow window onto a set of internal configuration tables. Software programs one address register with a table code, an entry index and an auto-advance flag. It then reads or writes one data register, and each data access reaches the chosen entry of the chosen table. Every table has an index mask of its own. The index is cut down to that mask before it is used, and when auto-advance is on it steps forward and wraps inside the mask, so a whole table can be streamed through the data register without touching the address register again.

Six tables are held in register banks inside the block. Eight more table codes are recognised but have no storage behind them: they read as zero and writes to them are dropped. Two codes are not valid. An access to one of them raises a sticky error flag and leaves the address register as it was. A write to the interrupt-vector table keeps only its architected fields and sends out a one-cycle reprogram pulse carrying the entry, the server number and the priority. A write to the 64-bit window table sends out a one-cycle recheck pulse carrying the entry number.

The port takes one access at a time. An accepted access passes through the states IDLE, LOOKUP and COMMIT. In IDLE, a valid request is taken (IDLE→LOOKUP). LOOKUP decodes the table code and masks the index, then always moves on (LOOKUP→COMMIT). COMMIT performs the access, updates the address register, error flag and strobes, and drives the response (COMMIT→IDLE). The block is ready only in IDLE.

Top module: `itp_port`

## Requirements
- R1: After reset the address register, the error flag and every stored table entry are zero, acc_ready is high, and rsp_valid, ivt_reprog and win_recheck are low.
- R2: A request is accepted on a clock edge where acc_valid and acc_ready are both high. acc_ready is then low until the response. rsp_valid is high for exactly one cycle, starting at the second clock edge after the accepting edge. Every write responds with rsp_rdata equal to zero.
- R3: acc_reg selects the register: 0 is the address register, 1 the data register, 2 the status register, and 3 a spare that reads zero and ignores writes. The address register holds the index in bits [8:0], the table code in bits [19:16] and auto-advance in bit 31. Every other bit is dropped on write and reads back as zero.
- R4: The table codes and index masks are: 0 list (7), 1 interrupt-vector (7), 8 translation-validation (511), 11 64-bit window (15), 12 32-bit domain (255), 13 error-enable (3). The index is ANDed with the mask before the access.
- R5: A data write to a backed table stores the value at the masked index. A data read returns the stored value.
- R6: With auto-advance set, every data access, read or write, to a valid code stores index = (masked index + 1) AND mask. With auto-advance clear, the address register keeps its written value.
- R7: The unbacked codes are 2 and 3 (mask 31), 4, 9 and 10 (mask 63), 5 (mask 7), and 6 and 7 (mask 255). They read zero, their writes change no state, and auto-advance still applies.
- R8: Codes 14 and 15 are invalid. A data access to one sets the error flag, reads zero, and leaves the address register unchanged.
- R9: The status register reads the error flag in bit 0. The flag stays set until a status write with bit 0 equal to one clears it. A status write with bit 0 equal to zero has no effect.
- R10: A data write to the interrupt-vector table keeps only the server (bits [31:24]), priority ([23:16]) and node ([3:0]) fields. It pulses ivt_reprog with the entry, the server field shifted right by 2, and the priority.
- R11: A data write to the 64-bit window table pulses win_recheck for one cycle, with win_entry equal to the masked index.
- R12: Reads, and writes to any other table, produce no ivt_reprog or win_recheck pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Port idle, request may be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 2 | Register select (R3) |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 64 | Read data (zero for writes) |
| err_flag | output | 1 | Sticky invalid-table flag |
| ivt_reprog | output | 1 | Interrupt-vector reprogram pulse |
| ivt_entry | output | $clog2(IVT_DEPTH) | Interrupt-vector entry written |
| ivt_server | output | 6 | Server number (field >> 2) |
| ivt_prio | output | 8 | Priority written |
| win_recheck | output | 1 | Window recheck pulse |
| win_entry | output | $clog2(WIN_DEPTH) | Window entry written |

## Verification
The bench builds the port with its default depths: 8-entry list and interrupt-vector tables, a 512-entry translation table, a 16-entry window table, a 256-entry domain table and a 4-entry error-enable table. With these depths, wrap-around is reached at both ends of the range. The bench tests the 4-entry table, where an over-wide index is cut to two bits, the 8-entry list table, where streaming crosses from entry 7 to entry 0, and the 512-entry table, where the full 9-bit index field wraps to zero. The 8-entry interrupt-vector table and the 16-entry window table give strobe entry widths of 3 and 4 bits, so the strobe index can be checked exactly.

// File: rtl/itp_pkg.sv
package itp_pkg;

    localparam int unsigned DW        = 64;
    localparam int unsigned IDX_W     = 9;
    localparam int unsigned TSEL_W    = 4;
    localparam int unsigned TSEL_LSB  = 16;
    localparam int unsigned AUTO_BIT  = 31;
    localparam int unsigned NUM_BANKS = 6;

    // interrupt-vector field layout
    localparam int unsigned SRV_MSB = 31;
    localparam int unsigned PRI_LSB = 16;
    localparam logic [DW-1:0] IVT_KEEP = 64'h0000_0000_FFFF_000F;

    // table codes
    localparam logic [TSEL_W-1:0] TBL_LIST  = 4'd0;
    localparam logic [TSEL_W-1:0] TBL_IVT   = 4'd1;
    localparam logic [TSEL_W-1:0] TBL_CAM   = 4'd2;
    localparam logic [TSEL_W-1:0] TBL_RBA   = 4'd3;
    localparam logic [TSEL_W-1:0] TBL_RCAM  = 4'd4;
    localparam logic [TSEL_W-1:0] TBL_MRT   = 4'd5;
    localparam logic [TSEL_W-1:0] TBL_PSTA  = 4'd6;
    localparam logic [TSEL_W-1:0] TBL_PSTB  = 4'd7;
    localparam logic [TSEL_W-1:0] TBL_TVT   = 4'd8;
    localparam logic [TSEL_W-1:0] TBL_TCAM  = 4'd9;
    localparam logic [TSEL_W-1:0] TBL_TDR   = 4'd10;
    localparam logic [TSEL_W-1:0] TBL_WIN   = 4'd11;
    localparam logic [TSEL_W-1:0] TBL_DOM   = 4'd12;
    localparam logic [TSEL_W-1:0] TBL_EEN   = 4'd13;

    // storage banks
    localparam logic [2:0] BANK_LIST = 3'd0;
    localparam logic [2:0] BANK_IVT  = 3'd1;
    localparam logic [2:0] BANK_TVT  = 3'd2;
    localparam logic [2:0] BANK_WIN  = 3'd3;
    localparam logic [2:0] BANK_DOM  = 3'd4;
    localparam logic [2:0] BANK_EEN  = 3'd5;

    // masks of tables without storage
    localparam logic [IDX_W-1:0] MASK_CACHE = 9'd31;
    localparam logic [IDX_W-1:0] MASK_CAM64 = 9'd63;
    localparam logic [IDX_W-1:0] MASK_MRT   = 9'd7;
    localparam logic [IDX_W-1:0] MASK_PEST  = 9'd255;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_COMMIT = 2'd2
    } itp_state_e;

    typedef enum logic [1:0] {
        REG_ADDR   = 2'd0,
        REG_DATA   = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } itp_reg_e;

    typedef enum logic [1:0] {
        KIND_BANK = 2'd0,
        KIND_HOLE = 2'd1,
        KIND_BAD  = 2'd2
    } itp_kind_e;

endpackage

// File: rtl/itp_decode.sv
module itp_decode
    import itp_pkg::*;
#(
    parameter int unsigned LIST_DEPTH = 8,
    parameter int unsigned IVT_DEPTH  = 8,
    parameter int unsigned TVT_DEPTH  = 512,
    parameter int unsigned WIN_DEPTH  = 16,
    parameter int unsigned DOM_DEPTH  = 256,
    parameter int unsigned EEN_DEPTH  = 4
) (
    input  logic [TSEL_W-1:0] tsel,
    output itp_kind_e         kind,
    output logic [2:0]        bank,
    output logic [IDX_W-1:0]  mask
);

    always_comb begin
        kind = KIND_BANK;
        bank = BANK_LIST;
        mask = '0;
        unique case (tsel)
            TBL_LIST: begin bank = BANK_LIST; mask = IDX_W'(LIST_DEPTH - 1); end
            TBL_IVT:  begin bank = BANK_IVT;  mask = IDX_W'(IVT_DEPTH - 1);  end
            TBL_TVT:  begin bank = BANK_TVT;  mask = IDX_W'(TVT_DEPTH - 1);  end
            TBL_WIN:  begin bank = BANK_WIN;  mask = IDX_W'(WIN_DEPTH - 1);  end
            TBL_DOM:  begin bank = BANK_DOM;  mask = IDX_W'(DOM_DEPTH - 1);  end
            TBL_EEN:  begin bank = BANK_EEN;  mask = IDX_W'(EEN_DEPTH - 1);  end
            TBL_CAM, TBL_RBA: begin
                kind = KIND_HOLE;
                mask = MASK_CACHE;
            end
            TBL_RCAM, TBL_TCAM, TBL_TDR: begin
                kind = KIND_HOLE;
                mask = MASK_CAM64;
            end
            TBL_MRT: begin
                kind = KIND_HOLE;
                mask = MASK_MRT;
            end
            TBL_PSTA, TBL_PSTB: begin
                kind = KIND_HOLE;
                mask = MASK_PEST;
            end
            default: kind = KIND_BAD;
        endcase
    end

endmodule

// File: rtl/itp_bank.sv
module itp_bank #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    widx,
    input  logic [WIDTH-1:0] wd,
    input  logic [AW-1:0]    ridx,
    output logic [WIDTH-1:0] rd
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wd;
        end
    end

    assign rd = mem[ridx];

endmodule

// File: rtl/itp_port.sv
module itp_port
    import itp_pkg::*;
#(
    parameter int unsigned LIST_DEPTH = 8,
    parameter int unsigned IVT_DEPTH  = 8,
    parameter int unsigned TVT_DEPTH  = 512,
    parameter int unsigned WIN_DEPTH  = 16,
    parameter int unsigned DOM_DEPTH  = 256,
    parameter int unsigned EEN_DEPTH  = 4,
    localparam int unsigned IVT_AW    = $clog2(IVT_DEPTH),
    localparam int unsigned WIN_AW    = $clog2(WIN_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic              acc_write,
    input  logic [1:0]        acc_reg,
    input  logic [63:0]       acc_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              err_flag,
    output logic              ivt_reprog,
    output logic [IVT_AW-1:0] ivt_entry,
    output logic [5:0]        ivt_server,
    output logic [7:0]        ivt_prio,
    output logic              win_recheck,
    output logic [WIN_AW-1:0] win_entry
);

    itp_state_e state_q, state_nx;

    // address register fields
    logic              auto_q;
    logic [TSEL_W-1:0] tsel_q;
    logic [IDX_W-1:0]  idx_q;

    // latched request
    logic              req_write_q;
    itp_reg_e          req_reg_q;
    logic [DW-1:0]     req_wdata_q;

    // lookup results
    itp_kind_e         dec_kind, lu_kind_q;
    logic [2:0]        dec_bank, lu_bank_q;
    logic [IDX_W-1:0]  dec_mask, lu_mask_q;
    logic [IDX_W-1:0]  lu_idx_q;

    logic [NUM_BANKS-1:0] bank_we;
    logic [DW-1:0]        bank_rd [NUM_BANKS];
    logic [DW-1:0]        ivt_wd;
    logic [DW-1:0]        addr_view;
    logic [DW-1:0]        rd_value;
    logic [IDX_W-1:0]     next_idx;
    logic                 data_ok;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign acc_ready = (state_q == ST_IDLE);

    // ---------------- decode ----------------
    itp_decode #(
        .LIST_DEPTH(LIST_DEPTH), .IVT_DEPTH(IVT_DEPTH), .TVT_DEPTH(TVT_DEPTH),
        .WIN_DEPTH(WIN_DEPTH), .DOM_DEPTH(DOM_DEPTH), .EEN_DEPTH(EEN_DEPTH)
    ) i_decode (
        .tsel (tsel_q),
        .kind (dec_kind),
        .bank (dec_bank),
        .mask (dec_mask)
    );

    // request and lookup pipeline registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_write_q <= 1'b0;
            req_reg_q   <= REG_ADDR;
            req_wdata_q <= '0;
            lu_kind_q   <= KIND_BANK;
            lu_bank_q   <= BANK_LIST;
            lu_mask_q   <= '0;
            lu_idx_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && acc_valid) begin
                req_write_q <= acc_write;
                req_reg_q   <= itp_reg_e'(acc_reg);
                req_wdata_q <= acc_wdata;
            end
            if (state_q == ST_LOOKUP) begin
                lu_kind_q <= dec_kind;
                lu_bank_q <= dec_bank;
                lu_mask_q <= dec_mask;
                lu_idx_q  <= idx_q & dec_mask;
            end
        end
    end

    // ---------------- table banks ----------------
    assign ivt_wd  = req_wdata_q & IVT_KEEP;
    assign data_ok = (state_q == ST_COMMIT) && (req_reg_q == REG_DATA)
                     && req_write_q && (lu_kind_q == KIND_BANK);

    for (genvar g = 0; g < int'(NUM_BANKS); g++) begin : g_bank
        localparam int unsigned D =
            (g == int'(BANK_LIST)) ? LIST_DEPTH :
            (g == int'(BANK_IVT))  ? IVT_DEPTH  :
            (g == int'(BANK_TVT))  ? TVT_DEPTH  :
            (g == int'(BANK_WIN))  ? WIN_DEPTH  :
            (g == int'(BANK_DOM))  ? DOM_DEPTH  : EEN_DEPTH;
        localparam int unsigned A = $clog2(D);

        assign bank_we[g] = data_ok && (lu_bank_q == 3'(g));

        itp_bank #(.DEPTH(D), .WIDTH(DW)) i_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (bank_we[g]),
            .widx (lu_idx_q[A-1:0]),
            .wd   ((g == int'(BANK_IVT)) ? ivt_wd : req_wdata_q),
            .ridx (lu_idx_q[A-1:0]),
            .rd   (bank_rd[g])
        );
    end

    // ---------------- commit values ----------------
    assign addr_view = {32'b0, auto_q, 11'b0, tsel_q, 7'b0, idx_q};
    assign next_idx  = (lu_idx_q + 1'b1) & lu_mask_q;

    always_comb begin
        rd_value = '0;
        if (!req_write_q) begin
            unique case (req_reg_q)
                REG_ADDR:   rd_value = addr_view;
                REG_DATA:   if (lu_kind_q == KIND_BANK) rd_value = bank_rd[lu_bank_q];
                REG_STATUS: rd_value = {63'b0, err_flag};
                default:    rd_value = '0;
            endcase
        end
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            err_flag    <= 1'b0;
            auto_q      <= 1'b0;
            tsel_q      <= '0;
            idx_q       <= '0;
            ivt_reprog  <= 1'b0;
            ivt_entry   <= '0;
            ivt_server  <= '0;
            ivt_prio    <= '0;
            win_recheck <= 1'b0;
            win_entry   <= '0;
        end else begin
            rsp_valid   <= 1'b0;
            ivt_reprog  <= 1'b0;
            win_recheck <= 1'b0;
            if (state_q == ST_COMMIT) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= rd_value;
                unique case (req_reg_q)
                    REG_ADDR: begin
                        if (req_write_q) begin
                            auto_q <= req_wdata_q[AUTO_BIT];
                            tsel_q <= req_wdata_q[TSEL_LSB +: TSEL_W];
                            idx_q  <= req_wdata_q[IDX_W-1:0];
                        end
                    end
                    REG_DATA: begin
                        if (lu_kind_q == KIND_BAD) begin
                            err_flag <= 1'b1;
                        end else begin
                            if (auto_q) idx_q <= next_idx;
                            if (data_ok && lu_bank_q == BANK_IVT) begin
                                ivt_reprog <= 1'b1;
                                ivt_entry  <= lu_idx_q[IVT_AW-1:0];
                                ivt_server <= req_wdata_q[SRV_MSB -: 6];
                                ivt_prio   <= req_wdata_q[PRI_LSB +: 8];
                            end
                            if (data_ok && lu_bank_q == BANK_WIN) begin
                                win_recheck <= 1'b1;
                                win_entry   <= lu_idx_q[WIN_AW-1:0];
                            end
                        end
                    end
                    REG_STATUS: begin
                        if (req_write_q && req_wdata_q[0]) err_flag <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/itp_port_chk.sv
module itp_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_ready,
    input logic        rsp_valid,
    input logic [63:0] rsp_rdata,
    input logic        err_flag,
    input logic        ivt_reprog,
    input logic        win_recheck
);

    assert_rsp_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |-> ##3 rsp_valid);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_err_set_on_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> rsp_valid);

    assert_err_clear_on_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> rsp_valid);

    assert_ivt_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ivt_reprog |-> (rsp_valid && rsp_rdata == 64'd0 && !win_recheck));

    assert_win_with_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        win_recheck |-> (rsp_valid && rsp_rdata == 64'd0));

endmodule

bind itp_port itp_port_chk i_itp_port_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .err_flag   (err_flag),
    .ivt_reprog (ivt_reprog),
    .win_recheck(win_recheck)
);

// File: tb/test_itp_port.sv
module test_itp_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_reg = 2'd0;
    logic [63:0] acc_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        err_flag;
    logic        ivt_reprog;
    logic [2:0]  ivt_entry;
    logic [5:0]  ivt_server;
    logic [7:0]  ivt_prio;
    logic        win_recheck;
    logic [3:0]  win_entry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // captured response
    logic        c_rsp, c_rdy_mid, c_ivt, c_win;
    logic [63:0] c_rd;
    logic [2:0]  c_ivt_e;
    logic [5:0]  c_srv;
    logic [7:0]  c_pri;
    logic [3:0]  c_win_e;

    always #2 clk = ~clk;   // 250 MHz

    itp_port i_itp_port (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_flag(err_flag),
        .ivt_reprog(ivt_reprog), .ivt_entry(ivt_entry), .ivt_server(ivt_server),
        .ivt_prio(ivt_prio), .win_recheck(win_recheck), .win_entry(win_entry)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one access; response captured at the negedge after the second edge past acceptance
    task automatic do_acc(input logic w, input logic [1:0] r, input logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_reg = r; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        c_rdy_mid = acc_ready;
        @(negedge clk);
        @(negedge clk);
        c_rsp = rsp_valid; c_rd = rsp_rdata;
        c_ivt = ivt_reprog; c_ivt_e = ivt_entry; c_srv = ivt_server; c_pri = ivt_prio;
        c_win = win_recheck; c_win_e = win_entry;
    endtask

    typedef struct packed {
        logic        w;
        logic [1:0]  r;
        logic [63:0] d;
        logic [63:0] e;
        logic        chk;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    // register select: 0 address, 1 data; rows exercise R3 R4 R5 R6
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 64'h8000_0006, 64'h0, 1'b0, 4'd6},
        '{1'b1, 2'd1, 64'h11,        64'h0, 1'b0, 4'd5},
        '{1'b1, 2'd1, 64'h22,        64'h0, 1'b0, 4'd5},
        '{1'b1, 2'd1, 64'h33,        64'h0, 1'b0, 4'd6},
        '{1'b0, 2'd0, 64'h0, 64'h8000_0001, 1'b1, 4'd6},
        '{1'b1, 2'd0, 64'h6,         64'h0, 1'b0, 4'd3},
        '{1'b0, 2'd1, 64'h0, 64'h11,        1'b1, 4'd5},
        '{1'b0, 2'd1, 64'h0, 64'h11,        1'b1, 4'd6},
        '{1'b0, 2'd0, 64'h0, 64'h6,         1'b1, 4'd3},
        '{1'b1, 2'd0, 64'h8000_0007, 64'h0, 1'b0, 4'd6},
        '{1'b0, 2'd1, 64'h0, 64'h22,        1'b1, 4'd5},
        '{1'b0, 2'd1, 64'h0, 64'h33,        1'b1, 4'd6},
        '{1'b0, 2'd0, 64'h0, 64'h8000_0001, 1'b1, 4'd6},
        '{1'b1, 2'd0, 64'h8008_01FF, 64'h0, 1'b0, 4'd4},
        '{1'b1, 2'd1, 64'hAAAA,      64'h0, 1'b1, 4'd2},
        '{1'b0, 2'd0, 64'h0, 64'h8008_0000, 1'b1, 4'd6},
        '{1'b1, 2'd0, 64'h0008_01FF, 64'h0, 1'b0, 4'd4},
        '{1'b0, 2'd1, 64'h0, 64'hAAAA,      1'b1, 4'd5},
        '{1'b1, 2'd0, 64'h800D_01FE, 64'h0, 1'b0, 4'd4},
        '{1'b1, 2'd1, 64'h5,         64'h0, 1'b0, 4'd4},
        '{1'b0, 2'd0, 64'h0, 64'h800D_0003, 1'b1, 4'd6},
        '{1'b1, 2'd0, 64'h000D_0006, 64'h0, 1'b0, 4'd4},
        '{1'b0, 2'd1, 64'h0, 64'h5,         1'b1, 4'd4},
        '{1'b0, 2'd0, 64'h0, 64'h000D_0006, 1'b1, 4'd3},
        '{1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 4'd3},
        '{1'b0, 2'd0, 64'h0, 64'h800F_01FF, 1'b1, 4'd3}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(acc_ready), 64'd1);
        check("R1 err", 64'(err_flag), 64'd0);
        check("R1 rsp", 64'(rsp_valid), 64'd0);
        check("R1 strobes", 64'({ivt_reprog, win_recheck}), 64'd0);
        do_acc(1'b0, 2'd0, '0);
        check("R1 addr", c_rd, 64'd0);
        do_acc(1'b0, 2'd1, '0);
        check("R1 table entry", c_rd, 64'd0);
        // R2 timing
        check("R2 busy", 64'(c_rdy_mid), 64'd0);
        check("R2 rsp_valid", 64'(c_rsp), 64'd1);

        for (int i = 0; i < NV; i++) begin
            do_acc(VECS[i].w, VECS[i].r, VECS[i].d);
            if (VECS[i].chk) begin
                checks++;
                if (c_rd !== VECS[i].e) begin
                    errors++;
                    $display("FAIL R%0d vec %0d: actual %h expected %h",
                             VECS[i].req, i, c_rd, VECS[i].e);
                end
            end
        end

        // R7 unbacked table, mask 31
        do_acc(1'b1, 2'd0, 64'h8002_001F);
        do_acc(1'b1, 2'd1, 64'h99);
        check("R2 write rdata", c_rd, 64'd0);
        do_acc(1'b0, 2'd0, '0);
        check("R7 autoinc wrap", c_rd, 64'h8002_0000);
        do_acc(1'b1, 2'd0, 64'h0002_001F);
        do_acc(1'b0, 2'd1, '0);
        check("R7 read zero", c_rd, 64'd0);
        check("R7 err untouched", 64'(err_flag), 64'd0);

        // R8 invalid code
        do_acc(1'b1, 2'd0, 64'h800E_0005);
        do_acc(1'b1, 2'd1, 64'h77);
        check("R8 err set", 64'(err_flag), 64'd1);
        do_acc(1'b0, 2'd0, '0);
        check("R8 addr kept", c_rd, 64'h800E_0005);
        do_acc(1'b0, 2'd1, '0);
        check("R8 read zero", c_rd, 64'd0);
        // R9 sticky flag
        do_acc(1'b1, 2'd2, 64'h0);
        do_acc(1'b0, 2'd2, '0);
        check("R9 status still set", c_rd, 64'd1);
        do_acc(1'b1, 2'd2, 64'h1);
        do_acc(1'b0, 2'd2, '0);
        check("R9 cleared", c_rd, 64'd0);
        // R3 spare register
        do_acc(1'b1, 2'd3, 64'h1234);
        do_acc(1'b0, 2'd3, '0);
        check("R3 spare zero", c_rd, 64'd0);

        // R10 interrupt-vector write
        do_acc(1'b1, 2'd0, 64'h0001_0003);
        do_acc(1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 pulse", 64'(c_ivt), 64'd1);
        check("R10 entry", 64'(c_ivt_e), 64'd3);
        check("R10 server", 64'(c_srv), 64'h3F);
        check("R10 prio", 64'(c_pri), 64'hFF);
        check("R12 no window pulse", 64'(c_win), 64'd0);
        do_acc(1'b0, 2'd1, '0);
        check("R10 stored fields", c_rd, 64'hFFFF_000F);
        check("R12 read no pulse", 64'(c_ivt), 64'd0);

        // R11 window write
        do_acc(1'b1, 2'd0, 64'h000B_0019);
        do_acc(1'b1, 2'd1, 64'h1234);
        check("R11 pulse", 64'(c_win), 64'd1);
        check("R11 entry", 64'(c_win_e), 64'd9);
        check("R12 no ivt pulse", 64'(c_ivt), 64'd0);
        do_acc(1'b0, 2'd1, '0);
        check("R5 window readback", c_rd, 64'h1234);
        check("R12 window read quiet", 64'(c_win), 64'd0);
        // R12 other table write
        do_acc(1'b1, 2'd0, 64'h000C_0001);
        do_acc(1'b1, 2'd1, 64'h55);
        check("R12 domain write quiet", 64'({c_ivt, c_win}), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule